// File: doc/BRIEF.md
# Endianness Byte-Swap Unit

This unit carries out the byte-order conversion operation of a packet-filter style instruction set. It takes the 8-bit instruction opcode, the 32-bit immediate and the 64-bit destination operand, and one clock later presents the converted value with a valid strobe and an illegal flag. Only the swap operation of the two arithmetic classes is accepted. Other opcodes are not decoded here and produce no strobe.

In the 32-bit arithmetic class, opcode bit 3 selects the target order. Whether bytes are actually reversed depends on that bit together with the compile-time host order. In the 64-bit arithmetic class the bytes are always reversed, and bit 3 is reserved. The immediate selects how many low-order bytes take part. Everything above that width is cleared.

Top module: `bswap_unit`

## Requirements
- R1: An input is accepted when `inValid` is high, opcode bits 7:4 equal 0xd, and opcode bits 2:0 equal 3'b100 (32-bit class, opcode 0xd4/0xdc) or 3'b111 (64-bit class, opcode 0xd7/0xdf). Any other opcode, or `inValid` low, produces no `outValid` pulse.
- R2: `outValid` is high exactly in the cycle after an accepted input. `result` and `illegal` keep their values until the next accepted input.
- R3: In the 32-bit class, opcode bit 3 clear targets little endian and bit 3 set targets big endian. Bytes are reversed only when the target differs from the host order given by `HOST_BIG_ENDIAN` (default 0, little endian).
- R4: In the 64-bit class with opcode bit 3 clear, the selected bytes are always reversed, whatever the host order.
- R5: In the 64-bit class with opcode bit 3 set, `illegal` is raised and `result` is zero.
- R6: An immediate of 16, 32 or 64 selects the low 2, 4 or 8 bytes as the swap field. When reversing, byte k of the field moves to byte (n-1-k).
- R7: Result bits at or above the selected width are zero, including when no reversal takes place.
- R8: Any immediate other than 16, 32 or 64 raises `illegal` and gives a zero `result`.
- R9: After reset, `outValid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input operation present |
| opcode | input | 8 | Instruction opcode |
| imm | input | 32 | Immediate giving swap width in bits |
| operand | input | 64 | Destination operand value |
| outValid | output | 1 | Result strobe, one cycle after acceptance |
| result | output | 64 | Converted value |
| illegal | output | 1 | Encoding was invalid for the operation |

## Verification
The hardest case to reach is the one where truncation happens without reversal. It occurs only when the 32-bit class targets the host order, and its output differs from a plain swap only in which bytes survive. The stimulus uses an operand with a distinct value in every byte and runs every width under both settings of bit 3 and both classes, so a wrong byte or a stale upper byte shows up. Rejected opcodes are placed between accepted ones, so that the hold behaviour of `result` can be seen at the ports.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  localparam logic [3:0] OP_SWAP   = 4'hd;
  localparam logic [2:0] CLS_ALU32 = 3'b100;
  localparam logic [2:0] CLS_ALU64 = 3'b111;
  localparam int         NUM_WIDTHS = 3;   // 16, 32, 64 bits

  typedef struct packed {
    logic                  fire;      // accepted operation this cycle
    logic                  bad;       // invalid encoding
    logic                  swap;      // reverse bytes
    logic [NUM_WIDTHS-1:0] widthSel;  // one-hot: [0]=16, [1]=32, [2]=64
  } swapCtl_t;
endpackage

// File: rtl/bswap_ctrl.sv
module bswap_ctrl
  import bswap_pkg::*;
#(
  parameter int IMM_W = 32,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic             inValid,
  input  logic [7:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output swapCtl_t         ctl
);
  logic isSwapOp;
  logic is32;
  logic is64;
  logic dirBit;
  logic badWidth;
  logic badSrc;

  always_comb begin
    isSwapOp = (opcode[7:4] == OP_SWAP);
    is32     = (opcode[2:0] == CLS_ALU32);
    is64     = (opcode[2:0] == CLS_ALU64);
    dirBit   = opcode[3];

    for (int w = 0; w < NUM_WIDTHS; w++) begin
      ctl.widthSel[w] = (imm == IMM_W'(16 << w));
    end
    badWidth = ~|ctl.widthSel;
    badSrc   = is64 & dirBit;

    ctl.fire = inValid & isSwapOp & (is32 | is64);
    ctl.bad  = badWidth | badSrc;
    // bit set targets big endian; reverse only when the target differs from host
    ctl.swap = is64 | (dirBit != HOST_BIG_ENDIAN);
  end
endmodule

// File: rtl/bswap_datapath.sv
module bswap_datapath
  import bswap_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapCtl_t          ctl,
  input  logic [DATA_W-1:0] operand,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int NBYTES = DATA_W / 8;

  logic [NUM_WIDTHS-1:0][DATA_W-1:0] revArr;
  logic [NUM_WIDTHS-1:0][DATA_W-1:0] keepArr;
  logic [DATA_W-1:0]                 nextResult;

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    localparam int NB = 2 << w;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign revArr[w][8*b +: 8]  = operand[8*(NB-1-b) +: 8];
      assign keepArr[w][8*b +: 8] = operand[8*b +: 8];
    end
    if (NB < NBYTES) begin : g_pad
      assign revArr[w][DATA_W-1:8*NB]  = '0;
      assign keepArr[w][DATA_W-1:8*NB] = '0;
    end
  end

  always_comb begin
    nextResult = '0;
    for (int w = 0; w < NUM_WIDTHS; w++) begin
      if (ctl.widthSel[w]) nextResult = ctl.swap ? revArr[w] : keepArr[w];
    end
    if (ctl.bad) nextResult = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= ctl.fire;
      if (ctl.fire) begin
        result  <= nextResult;
        illegal <= ctl.bad;
      end
    end
  end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
  import bswap_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        opcode,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] operand,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  swapCtl_t ctl;

  bswap_ctrl #(.IMM_W(IMM_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) i_ctrl (
    .inValid(inValid), .opcode(opcode), .imm(imm), .ctl(ctl)
  );

  bswap_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operand(operand),
    .outValid(outValid), .result(result), .illegal(illegal)
  );
endmodule

// File: rtl/bswap_unit_chk.sv
module bswap_unit_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [7:0]        opcode,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] operand,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  assert_no_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[7:4] != 4'hd) |=> !outValid);

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> ($stable(result) && $stable(illegal)));

  assert_always_swap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 8'hd7 && imm == IMM_W'(64)) |=>
      (outValid && result[7:0] == $past(operand[DATA_W-1 -: 8])));

  assert_reserved_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 8'hdf) |=> (outValid && illegal));

  assert_upper_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !illegal && $past(imm) == IMM_W'(16)) |-> (result[DATA_W-1:16] == '0));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (result == '0));
endmodule

bind bswap_unit bswap_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .imm(imm),
  .operand(operand), .outValid(outValid), .result(result), .illegal(illegal)
);

// File: tb/test_bswap_unit.sv
`timescale 1ns/1ps
module test_bswap_unit;
  localparam bit HOST_BIG = 1'b0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] imm = 32'd0;
  logic [63:0] operand = 64'd0;
  logic        outValid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  logic        expValid = 1'b0;
  logic [63:0] expResult = 64'd0;
  logic        expIll = 1'b0;

  always #10 clk = ~clk;

  bswap_unit #(.HOST_BIG_ENDIAN(HOST_BIG)) i_bswap_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .imm(imm),
    .operand(operand), .outValid(outValid), .result(result), .illegal(illegal)
  );

  function automatic logic [64:0] refModel(logic [7:0] op, logic [31:0] im, logic [63:0] d);
    logic [63:0] r = 64'd0;
    int nb;
    bit sw;
    if (im == 32'd16) nb = 2;
    else if (im == 32'd32) nb = 4;
    else if (im == 32'd64) nb = 8;
    else return {1'b1, 64'd0};
    if (op[2:0] == 3'd7 && op[3]) return {1'b1, 64'd0};
    sw = (op[2:0] == 3'd7) ? 1'b1 : (op[3] != HOST_BIG);
    for (int i = 0; i < nb; i++) begin
      if (sw) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
      else    r[8*i +: 8] = d[8*i +: 8];
    end
    return {1'b0, r};
  endfunction

  task automatic compare(string tag);
    checks++;
    if (outValid !== expValid || result !== expResult || illegal !== expIll) begin
      errors++;
      $display("FAIL %s: got valid=%b result=%h illegal=%b, expected valid=%b result=%h illegal=%b",
               tag, outValid, result, illegal, expValid, expResult, expIll);
    end
  endtask

  // check previous cycle's outcome, then apply a new input for the next edge
  task automatic step(string tag, logic v, logic [7:0] op, logic [31:0] im, logic [63:0] d);
    logic [64:0] m;
    @(negedge clk);
    compare(tag);
    m = refModel(op, im, d);
    if (v && op[7:4] == 4'hd && (op[2:0] == 3'd4 || op[2:0] == 3'd7)) begin
      expValid  = 1'b1;
      expResult = m[63:0];
      expIll    = m[64];
    end else begin
      expValid = 1'b0;
    end
    inValid = v; opcode = op; imm = im; operand = d;
  endtask

  localparam logic [63:0] PAT = 64'h1122334455667788;

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9");
    rstN = 1'b1;
    step("R9", 1'b0, 8'h00, 32'd0, 64'd0);
    // R3/R7: little-endian target on little-endian host: truncate only
    step("R9", 1'b1, 8'hd4, 32'd16, PAT);
    step("R7", 1'b1, 8'hd4, 32'd32, PAT);
    step("R7", 1'b1, 8'hd4, 32'd64, PAT);
    // R3/R6: big-endian target reverses
    step("R3", 1'b1, 8'hdc, 32'd16, PAT);
    step("R6", 1'b1, 8'hdc, 32'd32, PAT);
    step("R6", 1'b1, 8'hdc, 32'd64, PAT);
    // R4: 64-bit class always reverses
    step("R6", 1'b1, 8'hd7, 32'd16, PAT);
    step("R4", 1'b1, 8'hd7, 32'd32, 64'hfedcba9876543210);
    step("R4", 1'b1, 8'hd7, 32'd64, 64'hfedcba9876543210);
    // R5: reserved bit in 64-bit class
    step("R4", 1'b1, 8'hdf, 32'd64, PAT);
    step("R5", 1'b1, 8'hd4, 32'd16, 64'h0);
    // R8: bad widths
    step("R5", 1'b1, 8'hd4, 32'd8, PAT);
    step("R8", 1'b1, 8'hdc, 32'd48, PAT);
    step("R8", 1'b1, 8'hd7, 32'h0001_0040, PAT);
    step("R8", 1'b1, 8'hdc, 32'd32, 64'hcafef00d_a5a55a5a);
    // R1/R2: rejected opcodes and idle input hold the last result
    step("R8", 1'b1, 8'hd5, 32'd32, PAT);
    step("R1", 1'b1, 8'hc4, 32'd16, PAT);
    step("R1", 1'b1, 8'hdb, 32'd64, PAT);
    step("R1", 1'b0, 8'hd4, 32'd16, PAT);
    step("R2", 1'b0, 8'hd7, 32'd64, 64'h0);
    // R2: back-to-back accepts with varied data
    for (int k = 0; k < 24; k++) begin
      logic [63:0] d = {32'h9e3779b9 * (k + 1), 32'h7f4a7c15 ^ (k * 32'h01010101)};
      logic [7:0]  op = (k % 3 == 0) ? 8'hd4 : ((k % 3 == 1) ? 8'hdc : 8'hd7);
      logic [31:0] im = 32'd16 << (k % 3);
      step("R2", 1'b1, op, im, d);
    end
    step("R2", 1'b0, 8'h00, 32'd0, 64'd0);
    step("R2", 1'b0, 8'h00, 32'd0, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule